// File: doc/BRIEF.md
# Windowed Trap Entry Unit

This block carries out trap entry for a 32-bit processor that uses rotating register windows and a single trap level. A trap request arrives with an 8-bit trap type and a snapshot of the processor state. That snapshot holds the program counter, the next program counter, the current window pointer, the trap-enable bit, the supervisor bit and the trap base register. The unit then produces the state the processor resumes with.

If traps are enabled, the unit moves to the previous register window. It stores the two return addresses into two local registers of that new window, one per cycle, through a single register-file write port. It then clears the trap-enable bit, keeps the old supervisor bit as the previous-supervisor bit and forces supervisor mode. It forms the vector address from the trap base and the trap type and redirects fetch there.

Trap types in the external-interrupt group also raise an acknowledge strobe that carries the type. A trap that arrives while traps are disabled puts the unit in a sticky error state and does nothing else. The window count is a parameter with a default of 8.

Top module: `trap_entry_unit`

## Requirements
- R1: After reset, all state outputs are 0, `rf_we`, `done` and `irq_ack` are 0, and `err_state` is 0.
- R2: A request taken with `et_in` = 0 sets `err_state` on the next cycle. `err_state` then stays set until reset. No register write, `done` or `irq_ack` is produced, the state outputs keep their values, and later requests are ignored.
- R3: A request taken with `et_in` = 1 at clock edge E0 drives `rf_we` = 1 in the cycle after E0, with `rf_idx` = 17, `rf_wdata` = the captured PC and `rf_win` = the new window. In the next cycle it drives `rf_we` = 1 with `rf_idx` = 18 and `rf_wdata` = the captured NPC.
- R4: The new window is (`cwp_in` − 1) modulo NWIN, so window 0 becomes NWIN−1. `cwp_out` shows the new window while `done` is high.
- R5: `done` is high for exactly one cycle, the cycle right after the second write. In that cycle `et_out` = 0, `s_out` = 1 and `ps_out` = the captured `s_in`.
- R6: `tbr_out` = {`tbr_in`[31:12], trap type, 4'b0000}. `pc_out` equals `tbr_out`, and `npc_out` equals `tbr_out` + 4.
- R7: When trap type[7:4] = 4'h1 (the external-interrupt group), `irq_ack` is high together with `done` and `irq_ack_type` equals the trap type. For every other type, `irq_ack` stays 0.
- R8: A request is accepted only when the unit is idle. Requests and input changes during the three busy cycles do not change the writes or results of the trap in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_req | input | 1 | Trap request, sampled when idle |
| trap_type | input | 8 | Trap type |
| pc_in | input | 32 | Program counter at the trap |
| npc_in | input | 32 | Next program counter at the trap |
| cwp_in | input | 3 | Current window pointer |
| et_in | input | 1 | Trap-enable bit |
| s_in | input | 1 | Supervisor bit |
| tbr_in | input | 32 | Trap base register |
| pc_out | output | 32 | New program counter |
| npc_out | output | 32 | New next program counter |
| cwp_out | output | 3 | New window pointer |
| et_out | output | 1 | New trap-enable bit |
| s_out | output | 1 | New supervisor bit |
| ps_out | output | 1 | Previous-supervisor bit |
| tbr_out | output | 32 | New trap base register |
| rf_we | output | 1 | Register-file write enable |
| rf_win | output | 3 | Window addressed by the write |
| rf_idx | output | 5 | Register index within the window |
| rf_wdata | output | 32 | Write data |
| done | output | 1 | One-cycle pulse when trap entry completes |
| irq_ack | output | 1 | External-interrupt acknowledge strobe |
| irq_ack_type | output | 8 | Trap type carried by the acknowledge |
| err_state | output | 1 | Sticky error state |

## Verification
The assertions assume that `cwp_in` is always below NWIN. They also assume that the surrounding pipeline does not need a request to be held once it has been accepted, because the unit captures every operand at acceptance. The stimulus sweeps all 256 trap types, and each type derives its window from the type modulo the window count, so every window value stays in range. On some of these traps the bench keeps the request asserted and scrambles the inputs during the busy cycles. The error path is driven last, after which reset is applied again.

// File: rtl/trap_entry_pkg.sv
// Shared types for the trap entry unit.
// Assumes: the sequencer has exactly four phases.
package trap_entry_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SAVE_A = 2'd1,
        PH_SAVE_B = 2'd2,
        PH_FINISH = 2'd3
    } trap_phase_e;
endpackage

// File: rtl/trap_win_rot.sv
// Computes the previous register window, modulo the window count.
// Assumes: win_in < NWIN. Uses a plain wrapping subtract when NWIN is a power of two.
module trap_win_rot #(
    parameter int NWIN = 8,
    parameter int CWPW = 3
) (
    input  logic [CWPW-1:0] win_in,
    output logic [CWPW-1:0] win_prev
);
    localparam logic [CWPW-1:0] TOP_WIN = CWPW'(NWIN - 1);
    localparam bit POW2 = ((NWIN & (NWIN - 1)) == 0);

    generate
        if (POW2) begin : g_wrap
            // Wrapping subtract covers the modulo for free
            always_comb win_prev = win_in - CWPW'(1);
        end else begin : g_cmp
            // Explicit wrap from window 0 to the top window
            always_comb win_prev = (win_in == '0) ? TOP_WIN : win_in - CWPW'(1);
        end
    endgenerate

    // Result stays in range when the input is in range
    always_comb begin
        if (int'(win_in) < NWIN) begin
            // R4
            win_range_chk: assert (int'(win_prev) < NWIN);
        end
    end
endmodule

// File: rtl/trap_vec_calc.sv
// Forms the trap vector from the base field and the trap type, and flags external interrupts.
// Assumes: type occupies bits TTW+3:4 of the base register.
module trap_vec_calc #(
    parameter int DW = 32,
    parameter int TTW = 8,
    parameter logic [TTW-5:0] EXT_GROUP = 'h1
) (
    input  logic [DW-1:0]  base_in,
    input  logic [TTW-1:0] ttype,
    output logic [DW-1:0]  vec_addr,
    output logic [DW-1:0]  vec_next,
    output logic           is_ext
);
    localparam int LOW = TTW + 4;

    logic unused_base_lo;

    // Base field kept, type inserted above a 16-byte slot
    always_comb vec_addr = {base_in[DW-1:LOW], ttype, 4'b0000};
    // Fetch continues at the following word
    always_comb vec_next = vec_addr + DW'(4);
    // Group test ignores the low nibble of the type
    always_comb is_ext = (ttype[TTW-1:4] == EXT_GROUP);
    // Low bits of the base register are discarded
    always_comb unused_base_lo = ^base_in[LOW-1:0];
endmodule

// File: rtl/trap_entry_seq.sv
// Phase sequencer: accepts a request when idle, steps through two save cycles and a finish cycle.
// Assumes: a request with traps disabled is fatal until reset.
module trap_entry_seq
    import trap_entry_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic        et,
    output logic        start,
    output logic        fault,
    output trap_phase_e phase
);
    trap_phase_e phase_nx;
    logic        take;

    // A request counts only when idle and not in error
    always_comb take = req && (phase == PH_IDLE) && !fault;
    always_comb start = take && et;

    // Next phase selection
    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_IDLE:   if (start) phase_nx = PH_SAVE_A;
            PH_SAVE_A: phase_nx = PH_SAVE_B;
            PH_SAVE_B: phase_nx = PH_FINISH;
            PH_FINISH: phase_nx = PH_IDLE;
        endcase
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= phase_nx;
    end

    // Sticky error flag on a disabled-trap request
    always_ff @(posedge clk) begin
        if (!rst_n)                 fault <= 1'b0;
        else if (take && !et)       fault <= 1'b1;
    end

    // R2
    fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> phase == PH_IDLE);
endmodule

// File: rtl/trap_entry_unit.sv
// Trap entry unit: captures state on an accepted request, writes both return addresses into
// the new window, then presents the updated processor state with a one-cycle done pulse.
// Assumes: cwp_in < NWIN; operands need not be held after acceptance.
module trap_entry_unit
    import trap_entry_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int DW = 32,
    parameter int TTW = 8,
    parameter int PC_SLOT = 17,
    parameter int NPC_SLOT = 18,
    localparam int CWPW = (NWIN > 1) ? $clog2(NWIN) : 1,
    localparam int IDXW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trap_req,
    input  logic [TTW-1:0]  trap_type,
    input  logic [DW-1:0]   pc_in,
    input  logic [DW-1:0]   npc_in,
    input  logic [CWPW-1:0] cwp_in,
    input  logic            et_in,
    input  logic            s_in,
    input  logic [DW-1:0]   tbr_in,
    output logic [DW-1:0]   pc_out,
    output logic [DW-1:0]   npc_out,
    output logic [CWPW-1:0] cwp_out,
    output logic            et_out,
    output logic            s_out,
    output logic            ps_out,
    output logic [DW-1:0]   tbr_out,
    output logic            rf_we,
    output logic [CWPW-1:0] rf_win,
    output logic [IDXW-1:0] rf_idx,
    output logic [DW-1:0]   rf_wdata,
    output logic            done,
    output logic            irq_ack,
    output logic [TTW-1:0]  irq_ack_type,
    output logic            err_state
);
    trap_phase_e     phase;
    logic            start;
    logic            fault;
    logic [CWPW-1:0] win_prev;
    logic [DW-1:0]   vec_addr;
    logic [DW-1:0]   vec_next;
    logic            is_ext;

    logic [TTW-1:0]  cap_tt;
    logic [DW-1:0]   cap_pc;
    logic [DW-1:0]   cap_npc;
    logic [CWPW-1:0] cap_win;
    logic            cap_s;
    logic [DW-1:0]   cap_tbr;

    trap_entry_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (trap_req),
        .et    (et_in),
        .start (start),
        .fault (fault),
        .phase (phase)
    );

    trap_win_rot #(.NWIN(NWIN), .CWPW(CWPW)) u_rot (
        .win_in   (cwp_in),
        .win_prev (win_prev)
    );

    trap_vec_calc #(.DW(DW), .TTW(TTW)) u_vec (
        .base_in  (cap_tbr),
        .ttype    (cap_tt),
        .vec_addr (vec_addr),
        .vec_next (vec_next),
        .is_ext   (is_ext)
    );

    // Capture operands when a trap is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_tt  <= '0;
            cap_pc  <= '0;
            cap_npc <= '0;
            cap_win <= '0;
            cap_s   <= 1'b0;
            cap_tbr <= '0;
        end else if (start) begin
            cap_tt  <= trap_type;
            cap_pc  <= pc_in;
            cap_npc <= npc_in;
            cap_win <= win_prev;
            cap_s   <= s_in;
            cap_tbr <= tbr_in;
        end
    end

    // Single write port: return PC first, return NPC second
    always_comb begin
        rf_we    = (phase == PH_SAVE_A) || (phase == PH_SAVE_B);
        rf_win   = rf_we ? cap_win : '0;
        rf_idx   = (phase == PH_SAVE_A) ? IDXW'(PC_SLOT) :
                   (phase == PH_SAVE_B) ? IDXW'(NPC_SLOT) : '0;
        rf_wdata = (phase == PH_SAVE_A) ? cap_pc :
                   (phase == PH_SAVE_B) ? cap_npc : '0;
    end

    // Commit the new processor state alongside the second write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_out  <= '0;
            npc_out <= '0;
            cwp_out <= '0;
            et_out  <= 1'b0;
            s_out   <= 1'b0;
            ps_out  <= 1'b0;
            tbr_out <= '0;
        end else if (phase == PH_SAVE_B) begin
            pc_out  <= vec_addr;
            npc_out <= vec_next;
            cwp_out <= cap_win;
            et_out  <= 1'b0;
            s_out   <= 1'b1;
            ps_out  <= cap_s;
            tbr_out <= vec_addr;
        end
    end

    // Completion and acknowledge strobes
    always_comb begin
        done         = (phase == PH_FINISH);
        irq_ack      = done && is_ext;
        irq_ack_type = irq_ack ? cap_tt : '0;
        err_state    = fault;
    end

    // R3
    save_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && rf_idx == IDXW'(PC_SLOT)) |=> (rf_we && rf_idx == IDXW'(NPC_SLOT)));
    // R5
    done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(rf_we && rf_idx == IDXW'(NPC_SLOT)));
    // R5
    done_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!et_out && s_out));
    // R6
    vec_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (npc_out == pc_out + DW'(4) && pc_out == tbr_out));
    // R7
    ack_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> done);
    // R2
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_state |=> (err_state && !rf_we && !done));
    // R4
    cwp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> int'(cwp_out) < NWIN);
endmodule

// File: tb/sim_trap_entry_unit.sv
module sim_trap_entry_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_req = 1'b0;
    logic [7:0]  trap_type = '0;
    logic [31:0] pc_in = '0, npc_in = '0, tbr_in = '0;
    logic [2:0]  cwp_in = '0;
    logic        et_in = 1'b0, s_in = 1'b0;
    logic [31:0] pc_out, npc_out, tbr_out, rf_wdata;
    logic [2:0]  cwp_out, rf_win;
    logic        et_out, s_out, ps_out, rf_we, done, irq_ack, err_state;
    logic [4:0]  rf_idx;
    logic [7:0]  irq_ack_type;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    trap_entry_unit u0 (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_type(trap_type),
        .pc_in(pc_in), .npc_in(npc_in), .cwp_in(cwp_in), .et_in(et_in), .s_in(s_in),
        .tbr_in(tbr_in), .pc_out(pc_out), .npc_out(npc_out), .cwp_out(cwp_out),
        .et_out(et_out), .s_out(s_out), .ps_out(ps_out), .tbr_out(tbr_out),
        .rf_we(rf_we), .rf_win(rf_win), .rf_idx(rf_idx), .rf_wdata(rf_wdata),
        .done(done), .irq_ack(irq_ack), .irq_ack_type(irq_ack_type), .err_state(err_state)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic one_trap(input int tt, input bit hold);
        logic [31:0] pc, npc, tbr, vec;
        logic [2:0]  cw, nw;
        logic        s;
        pc  = 32'h1000_0000 + 32'(tt * 16);
        npc = pc ^ 32'h0000_0F04;
        tbr = 32'h5A5A_5ABC + 32'(tt << 12);
        cw  = 3'(tt % 8);
        s   = 1'((tt >> 1) & 1);
        nw  = 3'((int'(cw) + 7) % 8);
        vec = (tbr & 32'hFFFF_F000) | 32'(tt << 4);
        @(negedge clk);
        trap_req = 1'b1; trap_type = 8'(tt); pc_in = pc; npc_in = npc;
        tbr_in = tbr; cwp_in = cw; s_in = s; et_in = 1'b1;
        @(negedge clk);
        chk("R3 we first", {31'b0, rf_we}, 32'd1);
        chk("R3 idx first", {27'b0, rf_idx}, 32'd17);
        chk("R3 pc data", rf_wdata, pc);
        chk("R4 write window", {29'b0, rf_win}, {29'b0, nw});
        if (hold) begin
            trap_type = ~trap_type; pc_in = ~pc_in; npc_in = ~npc_in;
            tbr_in = ~tbr_in; cwp_in = ~cwp_in; s_in = ~s_in;
        end else trap_req = 1'b0;
        @(negedge clk);
        chk("R3 we second", {31'b0, rf_we}, 32'd1);
        chk("R3 idx second", {27'b0, rf_idx}, 32'd18);
        chk("R8 npc data", rf_wdata, npc);
        chk("R5 no early done", {31'b0, done}, 32'd0);
        @(negedge clk);
        trap_req = 1'b0;
        chk("R5 done", {31'b0, done}, 32'd1);
        chk("R4 cwp_out", {29'b0, cwp_out}, {29'b0, nw});
        chk("R5 et/s/ps", {29'b0, et_out, s_out, ps_out}, {29'b0, 1'b0, 1'b1, s});
        chk("R6 tbr_out", tbr_out, vec);
        chk("R6 pc_out", pc_out, vec);
        chk("R6 npc_out", npc_out, vec + 32'd4);
        chk("R7 ack", {31'b0, irq_ack}, {31'b0, (tt >> 4) == 1});
        if ((tt >> 4) == 1) chk("R7 ack type", {24'b0, irq_ack_type}, 32'(tt));
        chk("R3 no write at done", {31'b0, rf_we}, 32'd0);
        @(negedge clk);
        chk("R5 done one cycle", {31'b0, done | irq_ack | rf_we}, 32'd0);
    endtask

    initial begin
        logic [31:0] keep_pc;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 pc_out", pc_out, 32'd0);
        chk("R1 strobes", {28'b0, rf_we, done, irq_ack, err_state}, 32'd0);
        chk("R1 state bits", {29'b0, et_out, s_out, ps_out}, 32'd0);
        rst_n = 1'b1;
        for (int tt = 0; tt < 256; tt++) one_trap(tt, (tt % 5) == 0);
        // R2 trap with traps disabled
        keep_pc = pc_out;
        @(negedge clk);
        trap_req = 1'b1; et_in = 1'b0; trap_type = 8'h13;
        @(negedge clk);
        chk("R2 err set", {31'b0, err_state}, 32'd1);
        chk("R2 no write", {31'b0, rf_we}, 32'd0);
        et_in = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R2 err sticky", {31'b0, err_state}, 32'd1);
            chk("R2 quiet", {29'b0, rf_we, done, irq_ack}, 32'd0);
            chk("R2 state kept", pc_out, keep_pc);
        end
        trap_req = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 err cleared", {31'b0, err_state}, 32'd0);
        chk("R1 pc_out cleared", pc_out, 32'd0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule